// File: doc/BRIEF.md
# Weighted Threshold Gate with Stuck-at Fault Injection

This block is a linear threshold gate with a configurable number of binary inputs. Each input has a signed integer weight, and the gate has one signed integer threshold. The gate adds up the weights of the inputs that are high and drives a 1 when that sum reaches the threshold. Weights and threshold are loaded one at a time through a small write port.

Alongside the fault-free evaluation, the block computes a second, faulty evaluation under one selected stuck-at fault. An input stuck-at-0 is modelled by treating that input's weight as zero. An input stuck-at-1 drops the input's term from the sum and lowers the threshold by that weight. Output stuck-at faults force the faulty result to a constant. A detect flag marks every vector on which the two results differ, so a bench can score candidate test vectors one per cycle.

Top module: `thresh_gate_fi`

## Requirements
- R1: One clock after an input vector is presented, `good_q` is 1 exactly when the signed sum of the weights of the high inputs is greater than or equal to the threshold. Input bit `x_in[i]` uses weight slot i.
- R2: When `cfg_we` is high at a clock edge, the weight slot `cfg_addr` is written for addresses 0 to N_IN-1, and the threshold is written for address N_IN. Both are W_W-bit two's-complement values. Writes to larger addresses change nothing, and nothing changes while `cfg_we` is low.
- R3: The sum is computed without wrap-around for every combination of extreme weights and threshold. With four weights of +31 and threshold +31, all inputs high gives 1. With four weights of -32 and threshold -32, all inputs high gives 0.
- R4: With `flt_mode` = 3'b001 (input stuck-at-0) on index k < N_IN, `bad_q` equals the gate evaluated with weight k replaced by zero.
- R5: With `flt_mode` = 3'b010 (input stuck-at-1) on index k < N_IN, `bad_q` is 1 exactly when the sum excluding input k is at least the threshold minus weight k.
- R6: `flt_mode` = 3'b011 forces `bad_q` to 0 and `flt_mode` = 3'b100 forces it to 1, whatever the inputs.
- R7: `detect_q` is 1 exactly when `good_q` and `bad_q` differ, in the same cycle.
- R8: `flt_mode` = 3'b000, any code from 3'b101 to 3'b111, or an input fault whose index is N_IN or above, makes `bad_q` equal to `good_q`.
- R9: While `rst` is high, all three outputs are 0. Reset also clears every weight and the threshold to zero.
- R10: With weights (2,1,1,0) and threshold 3, input-0 stuck-at-0 is detected exactly when x0 is 1 and x1 or x2 is 1. Input-0 stuck-at-1 is detected exactly when x0 is 0 and x1 or x2 is 1.
- R11: For two inputs of equal weight, the vectors that detect a fault on one are those that detect the same fault on the other, with the two bit positions swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Weight slot, or N_IN for the threshold |
| cfg_data | input | W_W | Signed value to write |
| x_in | input | N_IN | Binary input vector |
| flt_mode | input | 3 | Fault type code |
| flt_idx | input | AW | Input index for an input fault |
| good_q | output | 1 | Registered fault-free output |
| bad_q | output | 1 | Registered faulty output |
| detect_q | output | 1 | Registered difference flag |

## Verification
The masking properties assume that the input vector, fault code and fault index held before an edge are the ones that produced the outputs after that edge. They also assume that the configuration does not change between those two points. The stimulus guarantees this by writing the configuration only while it evaluates no vector, and by changing the vector, code and index only on the falling clock edge. Out-of-range indices and unused fault codes are driven on purpose, because the properties cover them as no-fault cases.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'b000,
        FLT_IN_SA0  = 3'b001,
        FLT_IN_SA1  = 3'b010,
        FLT_OUT_SA0 = 3'b011,
        FLT_OUT_SA1 = 3'b100
    } flt_e;

    typedef struct packed {
        logic good;
        logic bad;
        logic det;
    } tg_res_t;

    // accumulator width: weight width, growth for n terms, plus headroom for T - w
    function automatic int acc_width(input int n_in, input int w_w);
        return w_w + $clog2(n_in + 1) + 1;
    endfunction

endpackage

// File: rtl/tg_cfg.sv
module tg_cfg #(
    parameter int N_IN = 4,
    parameter int W_W  = 6,
    parameter int AW   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [W_W-1:0]            data,
    output logic [N_IN-1:0][W_W-1:0]  wt_q,
    output logic [W_W-1:0]            thr_q
);

    for (genvar i = 0; i < N_IN; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                wt_q[i] <= '0;
            else if (we && addr == AW'(i))
                wt_q[i] <= data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= '0;
        else if (we && addr == AW'(N_IN))
            thr_q <= data;
    end

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(thr_q) && $stable(wt_q)));

endmodule

// File: rtl/tg_fault.sv
module tg_fault
    import tg_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int W_W  = 6,
    parameter int AW   = 3,
    parameter int SW   = 10
) (
    input  logic [N_IN-1:0][W_W-1:0]  wt,
    input  logic [W_W-1:0]            thr,
    input  logic [2:0]                mode,
    input  logic [AW-1:0]             idx,
    output logic [N_IN-1:0][W_W-1:0]  f_wt,
    output logic [SW-1:0]             f_thr,
    output logic                      force_en,
    output logic                      force_val
);

    logic in_fault;
    logic is_sa1;
    logic [SW-1:0] sel_w_ext;
    logic [SW-1:0] thr_ext;

    assign in_fault = (mode == FLT_IN_SA0) || (mode == FLT_IN_SA1);
    assign is_sa1   = (mode == FLT_IN_SA1);
    assign thr_ext  = {{(SW-W_W){thr[W_W-1]}}, thr};

    // weight removal per slot; out-of-range index matches no slot
    for (genvar i = 0; i < N_IN; i++) begin : g_mask
        assign f_wt[i] = (in_fault && idx == AW'(i)) ? '0 : wt[i];
    end

    always_comb begin
        sel_w_ext = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (idx == AW'(i))
                sel_w_ext = {{(SW-W_W){wt[i][W_W-1]}}, wt[i]};
        end
    end

    assign f_thr = is_sa1 ? (thr_ext - sel_w_ext) : thr_ext;

    always_comb begin
        force_en  = 1'b0;
        force_val = 1'b0;
        case (mode)
            FLT_OUT_SA0: begin force_en = 1'b1; force_val = 1'b0; end
            FLT_OUT_SA1: begin force_en = 1'b1; force_val = 1'b1; end
            default:     begin force_en = 1'b0; force_val = 1'b0; end
        endcase
    end

endmodule

// File: rtl/tg_eval.sv
module tg_eval #(
    parameter int N_IN = 4,
    parameter int W_W  = 6,
    parameter int SW   = 10
) (
    input  logic [N_IN-1:0]           x,
    input  logic [N_IN-1:0][W_W-1:0]  wt,
    input  logic [SW-1:0]             thr,
    output logic                      fire
);

    logic signed [SW-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (x[i])
                acc = acc + $signed({{(SW-W_W){wt[i][W_W-1]}}, wt[i]});
        end
    end

    assign fire = (acc >= $signed(thr));

endmodule

// File: rtl/thresh_gate_fi.sv
module thresh_gate_fi
    import tg_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int W_W  = 6,
    localparam int AW  = $clog2(N_IN + 1),
    localparam int SW  = acc_width(N_IN, W_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [W_W-1:0]   cfg_data,
    input  logic [N_IN-1:0]  x_in,
    input  logic [2:0]       flt_mode,
    input  logic [AW-1:0]    flt_idx,
    output logic             good_q,
    output logic             bad_q,
    output logic             detect_q
);

    logic [N_IN-1:0][W_W-1:0] wt;
    logic [W_W-1:0]           thr;
    logic [N_IN-1:0][W_W-1:0] f_wt;
    logic [SW-1:0]            f_thr;
    logic [SW-1:0]            g_thr;
    logic                     force_en, force_val;
    logic                     fire_good, fire_bad;
    tg_res_t                  res_d, res_q;

    tg_cfg #(.N_IN(N_IN), .W_W(W_W), .AW(AW)) i_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
        .wt_q(wt), .thr_q(thr)
    );

    tg_fault #(.N_IN(N_IN), .W_W(W_W), .AW(AW), .SW(SW)) i_fault (
        .wt(wt), .thr(thr), .mode(flt_mode), .idx(flt_idx),
        .f_wt(f_wt), .f_thr(f_thr), .force_en(force_en), .force_val(force_val)
    );

    assign g_thr = {{(SW-W_W){thr[W_W-1]}}, thr};

    tg_eval #(.N_IN(N_IN), .W_W(W_W), .SW(SW)) i_eval_good (
        .x(x_in), .wt(wt), .thr(g_thr), .fire(fire_good)
    );

    tg_eval #(.N_IN(N_IN), .W_W(W_W), .SW(SW)) i_eval_bad (
        .x(x_in), .wt(f_wt), .thr(f_thr), .fire(fire_bad)
    );

    always_comb begin
        res_d.good = fire_good;
        res_d.bad  = force_en ? force_val : fire_bad;
        res_d.det  = res_d.good ^ res_d.bad;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign good_q   = res_q.good;
    assign bad_q    = res_q.bad;
    assign detect_q = res_q.det;

    // value of the faulted input, for the masking properties
    logic sel_x;
    logic idx_ok;
    always_comb begin
        sel_x = 1'b0;
        for (int i = 0; i < N_IN; i++)
            if (flt_idx == AW'(i)) sel_x = x_in[i];
    end
    assign idx_ok = (flt_idx < AW'(N_IN));

    p_reset_clear_r9: assert property (@(posedge clk)
        $past(rst) |-> (!good_q && !bad_q && !detect_q));

    p_nofault_equal_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flt_mode) == FLT_NONE) |-> (good_q == bad_q));

    p_out_sa0_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flt_mode) == FLT_OUT_SA0) |-> !bad_q);

    p_out_sa1_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flt_mode) == FLT_OUT_SA1) |-> bad_q);

    p_sa0_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flt_mode) == FLT_IN_SA0 && $past(idx_ok) && !$past(sel_x))
            |-> !detect_q);

    p_sa1_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flt_mode) == FLT_IN_SA1 && $past(idx_ok) && $past(sel_x))
            |-> !detect_q);

    p_detect_diff_r7: assert property (@(posedge clk) disable iff (rst)
        detect_q == (good_q ^ bad_q));

endmodule

// File: tb/test_thresh_gate_fi.sv
`timescale 1ns/1ps
module test_thresh_gate_fi;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [5:0] cfg_data = '0;
    logic [3:0] x_in = '0;
    logic [2:0] flt_mode = '0;
    logic [2:0] flt_idx = '0;
    logic       good_q, bad_q, detect_q;

    int checks = 0;
    int errors = 0;
    int mw[4];
    int mt;
    bit done = 0;

    always #4 clk = ~clk;

    thresh_gate_fi i_thresh_gate_fi (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .x_in(x_in), .flt_mode(flt_mode), .flt_idx(flt_idx),
        .good_q(good_q), .bad_q(bad_q), .detect_q(detect_q)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [3:0] x, input int mode, input int idx);
        int s, sf, tf;
        logic g, b;
        s = 0;
        for (int i = 0; i < 4; i++) if (x[i]) s += mw[i];
        g = (s >= mt);
        b = g;
        if ((mode == 1 || mode == 2) && idx < 4) begin
            sf = s - (x[idx] ? mw[idx] : 0);
            tf = (mode == 2) ? mt - mw[idx] : mt;
            b = (sf >= tf);
        end else if (mode == 3) b = 1'b0;
        else if (mode == 4) b = 1'b1;
        return {g, b, g ^ b};
    endfunction

    task automatic wr(input int addr, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr[2:0]; cfg_data = val[5:0];
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 4) mw[addr] = val;
        else if (addr == 4) mt = val;
    endtask

    task automatic run(input logic [3:0] x, input int mode, input int idx, output logic [2:0] got);
        @(negedge clk);
        x_in = x; flt_mode = mode[2:0]; flt_idx = idx[2:0];
        @(negedge clk);
        got = {good_q, bad_q, detect_q};
    endtask

    task automatic sweep(input string req, input int mode, input int idx);
        logic [2:0] got;
        for (int v = 0; v < 16; v++) begin
            run(v[3:0], mode, idx, got);
            chk(req, got, model(v[3:0], mode, idx));
        end
    endtask

    task automatic t_reset;
        x_in = 4'hF; flt_mode = 3'd4;
        repeat (3) @(negedge clk);
        chk("R9 outputs in reset", {good_q, bad_q, detect_q}, 3'b000);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) mw[i] = 0;
        mt = 0;
        sweep("R9 config cleared by reset", 0, 0);
    endtask

    task automatic t_cfg;
        wr(0, 3); wr(1, -2); wr(2, 5); wr(3, 1); wr(4, 4);
        sweep("R1 weighted sum vs threshold", 0, 0);
        wr(5, 31); wr(6, -32); wr(7, 1);
        sweep("R2 high addresses ignored", 0, 0);
        @(negedge clk); cfg_addr = 3'd4; cfg_data = 6'd1;
        @(negedge clk);
        sweep("R2 no write without strobe", 0, 0);
    endtask

    task automatic t_overflow;
        logic [2:0] got;
        for (int i = 0; i < 4; i++) wr(i, 31);
        wr(4, 31);
        run(4'hF, 0, 0, got); chk("R3 max positive sum", got, 3'b110);
        run(4'h0, 0, 0, got); chk("R3 empty sum below +31", got, 3'b000);
        for (int i = 0; i < 4; i++) wr(i, -32);
        wr(4, -32);
        run(4'hF, 0, 0, got); chk("R3 max negative sum", got, 3'b000);
        run(4'h1, 0, 0, got); chk("R3 equal to threshold", got, 3'b110);
        sweep("R3 input sa1 extreme threshold", 2, 3);
    endtask

    task automatic t_faults;
        wr(0, 3); wr(1, -2); wr(2, 5); wr(3, -4); wr(4, 2);
        for (int k = 0; k < 4; k++) begin
            sweep("R4 input stuck-at-0", 1, k);
            sweep("R5 input stuck-at-1", 2, k);
        end
        sweep("R6 output stuck-at-0", 3, 0);
        sweep("R6 output stuck-at-1", 4, 0);
        sweep("R7 detect on output faults", 4, 2);
        sweep("R8 code 5", 5, 0);
        sweep("R8 code 7", 7, 1);
        sweep("R8 index out of range", 1, 4);
        sweep("R8 index out of range sa1", 2, 6);
    endtask

    task automatic t_example;
        logic [2:0] got;
        logic e;
        wr(0, 2); wr(1, 1); wr(2, 1); wr(3, 0); wr(4, 3);
        for (int v = 0; v < 8; v++) begin
            run(v[3:0], 1, 0, got);
            e = v[0] && (v[1] || v[2]);
            chk("R10 x0 stuck-at-0 detect set", {2'b00, got[0]}, {2'b00, e});
            run(v[3:0], 2, 0, got);
            e = !v[0] && (v[1] || v[2]);
            chk("R10 x0 stuck-at-1 detect set", {2'b00, got[0]}, {2'b00, e});
        end
    endtask

    task automatic t_swap;
        logic [2:0] g1, g2;
        logic [3:0] sv;
        for (int m = 1; m <= 2; m++) begin
            for (int v = 0; v < 16; v++) begin
                sv = v[3:0];
                sv[1] = v[2]; sv[2] = v[1];
                run(v[3:0], m, 1, g1);
                run(sv, m, 2, g2);
                chk("R11 equal-weight swap", {2'b00, g2[0]}, {2'b00, g1[0]});
            end
        end
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset;
        t_cfg;
        t_overflow;
        t_faults;
        t_example;
        t_swap;
        done = 1;
        finish_run;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run;
        end
    end

endmodule